// File: doc/BRIEF.md
# Bus Cycle Controller for an 8-bit Processor Core

This block runs the external bus of a small 8-bit processor. It is a subordinate engine. A separate instruction sequencer posts a typed request, and the controller acts only on that request. It never starts a cycle by itself.

A request asks for one of four kinds of work:
- a memory transfer, either a read or a write;
- an I/O transfer, either a read or a write;
- a pure delay, one clock long or a parameterised longer length (three clocks by default);
- nothing, which is the null request.

Transfers drive a 16-bit address, an 8-bit data path and active-low read and write strobes. Delay requests add idle bus clocks. These idle clocks keep instruction timing the same as on older hardware.

The sequencer gets three handshakes back from the controller:
- an accept acknowledge, in the clock the request is taken;
- an early data-ready flag, one clock ahead;
- the data acknowledge itself.

The early flag lets the sequencer move into an execution state that does not wait on the acknowledge. An execution state held over several clocks therefore runs only once.

The FSM has five states: `ST_IDLE`, `ST_ADDR`, `ST_STRB`, `ST_DONE` and `ST_DLY`. Its transitions are:
- `ST_IDLE` goes to `ST_ADDR` when a transfer request is accepted.
- `ST_IDLE` goes to `ST_DLY` when a delay request is accepted.
- `ST_IDLE` stays in `ST_IDLE` when there is no valid request, or the request is null or reserved.
- `ST_ADDR` goes to `ST_STRB`.
- `ST_STRB` goes to `ST_DONE`.
- `ST_DONE` goes to `ST_IDLE`.
- `ST_DLY` stays in `ST_DLY` while the delay counter is non-zero.
- `ST_DLY` goes to `ST_IDLE` when the counter reaches zero.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: During and right after reset, the outputs are in their idle state. The strobes `rd_n` and `wr_n` are high. `req_ack`, `early_ack`, `data_ack`, `io_m` and `bus_oe` are low. `rd_data` is 0.
- R2: The request codes on `req_kind` are: 0 = null, 1 = memory read, 2 = memory write, 3 = I/O read, 4 = I/O write, 5 = one-clock delay, 6 = long delay, 7 = reserved. In `ST_IDLE`, a held `req_valid` with code 1 to 6 raises `req_ack` in that same clock. The kind, address and write data are latched at the closing edge of that clock. While a cycle is in progress, `req_ack` stays low.
- R3: Codes 0 and 7 are never acknowledged. They produce no strobe and no acknowledge, and the controller stays idle.
- R4: A memory read uses the three clocks after acceptance. The address is on `bus_addr` in all three. `rd_n` is low only in the second clock. `data_ack` is high in the third clock. In that third clock, `rd_data` shows the `bus_din` value sampled at the end of the second clock.
- R5: A write drives `bus_oe` high and the latched data on `bus_dout` for all three clocks. `wr_n` is low only in the second clock. `rd_n` stays high.
- R6: `early_ack` is high exactly in the clock before every `data_ack` clock, and at no other time.
- R7: For I/O codes 3 and 4, `io_m` is high during the cycle. `bus_addr` carries the low address byte in both halves. For memory codes, `io_m` is low and the full address is driven.
- R8: A one-clock delay (code 5) raises `early_ack` in the accept clock. It raises `data_ack` in the next clock. It does so with no strobe and with `bus_oe` low.
- R9: A long delay (code 6) gives `DLY_LONG` idle clocks after acceptance. `data_ack` is high in the last of them. There is no strobe and `bus_oe` is low.
- R10: `rd_data` changes only at the end of a read strobe clock. Write, delay and null requests leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Sequencer request pending, held until acknowledged |
| req_kind | input | 3 | Request code (see R2) |
| req_addr | input | 16 | Memory address, or I/O port in the low byte |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | Request accepted this clock |
| early_ack | output | 1 | Data acknowledge follows in the next clock |
| data_ack | output | 1 | Cycle complete / read data valid |
| rd_data | output | 8 | Captured read data |
| bus_addr | output | 16 | External address |
| bus_dout | output | 8 | External write data |
| bus_oe | output | 1 | Write data drive enable |
| bus_din | input | 8 | External read data |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | High for I/O cycles |

## Verification
A wrong state or a wrong counter value shows at the ports within one clock. It appears as a strobe in the wrong slot, a `data_ack` with no `early_ack` ahead of it, or an acceptance while busy. The bench compares every clock of every cycle against a per-clock expectation.

Some faults show later. A bad latch, a bad address-format path or a bad capture path shows as a wrong `bus_addr`, `bus_dout` or `rd_data`. It appears in the first clock after acceptance, or in the `data_ack` clock. A missed hold of `rd_data` appears at the end of the next non-read request.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_MRD  = 3'd1,
        K_MWR  = 3'd2,
        K_IORD = 3'd3,
        K_IOWR = 3'd4,
        K_DLY1 = 3'd5,
        K_DLYL = 3'd6,
        K_RSV  = 3'd7
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STRB,
        ST_DONE,
        ST_DLY
    } bus_state_e;

    function automatic logic kind_is_xfer(input logic [2:0] k);
        return (k == K_MRD) || (k == K_MWR) || (k == K_IORD) || (k == K_IOWR);
    endfunction

    function automatic logic kind_is_delay(input logic [2:0] k);
        return (k == K_DLY1) || (k == K_DLYL);
    endfunction

    function automatic logic kind_is_io(input logic [2:0] k);
        return (k == K_IORD) || (k == K_IOWR);
    endfunction

    function automatic logic kind_is_read(input logic [2:0] k);
        return (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic kind_is_write(input logic [2:0] k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction
endpackage

// File: rtl/bcc_dly_cnt.sv
module bcc_dly_cnt #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/bcc_addr_fmt.sv
module bcc_addr_fmt #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_in,
    input  logic          io_sel,
    output logic [AW-1:0] addr_out
);
    localparam int HW = AW / 2;

    always_comb begin
        if (io_sel) begin
            addr_out = {2{addr_in[HW-1:0]}};
        end else begin
            addr_out = addr_in;
        end
    end
endmodule

// File: rtl/bcc_rd_latch.sv
module bcc_rd_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap) begin
            q <= din;
        end
    end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int DLY_LONG = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic          early_ack,
    output logic          data_ack,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_din,
    output logic          rd_n,
    output logic          wr_n,
    output logic          io_m
);
    localparam int CW = $clog2(DLY_LONG + 1);

    bus_state_e    state_q, state_d;
    logic [2:0]    kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [CW-1:0] dly_cnt;
    logic [CW-1:0] dly_load;
    logic          accept;
    logic          xfer_active;
    logic          lat_io, lat_rd, lat_wr;

    assign accept   = (state_q == ST_IDLE) && req_valid &&
                      (kind_is_xfer(req_kind) || kind_is_delay(req_kind));
    assign dly_load = (req_kind == K_DLY1) ? '0 : CW'(DLY_LONG - 1);
    assign lat_io   = kind_is_io(kind_q);
    assign lat_rd   = kind_is_read(kind_q);
    assign lat_wr   = kind_is_write(kind_q);

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_NONE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q  <= req_kind;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = kind_is_xfer(req_kind) ? ST_ADDR : ST_DLY;
                end
            end
            ST_ADDR: state_d = ST_STRB;
            ST_STRB: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            ST_DLY:  state_d = (dly_cnt == '0) ? ST_IDLE : ST_DLY;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        req_ack     = accept;
        early_ack   = 1'b0;
        data_ack    = 1'b0;
        rd_n        = 1'b1;
        wr_n        = 1'b1;
        xfer_active = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                early_ack = accept && kind_is_delay(req_kind) && (dly_load == '0);
            end
            ST_ADDR: begin
                xfer_active = 1'b1;
            end
            ST_STRB: begin
                xfer_active = 1'b1;
                early_ack   = 1'b1;
                rd_n        = !lat_rd;
                wr_n        = !lat_wr;
            end
            ST_DONE: begin
                xfer_active = 1'b1;
                data_ack    = 1'b1;
            end
            ST_DLY: begin
                early_ack = (dly_cnt == CW'(1));
                data_ack  = (dly_cnt == '0);
            end
            default: begin
                xfer_active = 1'b0;
            end
        endcase
        io_m     = xfer_active && lat_io;
        bus_oe   = xfer_active && lat_wr;
        bus_dout = wdata_q;
    end

    bcc_dly_cnt #(.CW(CW)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (dly_load),
        .run      (state_q == ST_DLY),
        .cnt      (dly_cnt)
    );

    bcc_addr_fmt #(.AW(AW)) u_afmt (
        .addr_in  (addr_q),
        .io_sel   (lat_io),
        .addr_out (bus_addr)
    );

    bcc_rd_latch #(.DW(DW)) u_rdl (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   ((state_q == ST_STRB) && lat_rd),
        .din   (bus_din),
        .q     (rd_data)
    );
endmodule

// File: rtl/bcc_chk.sv
module bcc_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_kind,
    input logic          req_ack,
    input logic          early_ack,
    input logic          data_ack,
    input logic [DW-1:0] rd_data,
    input logic [AW-1:0] bus_addr,
    input logic          bus_oe,
    input logic          rd_n,
    input logic          wr_n,
    input logic          io_m
);
    localparam int HW = AW / 2;

    // R2
    ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> req_valid);

    // R2
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R3
    no_null_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (req_kind != 3'd0 && req_kind != 3'd7));

    // R4
    read_strobe_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> (data_ack && rd_n));

    // R5
    write_strobe_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (bus_oe && rd_n));

    // R6
    early_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_ack |=> data_ack);

    // R6
    data_after_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ack |-> $past(early_ack));

    // R7
    io_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_m |-> (bus_addr[AW-1:HW] == bus_addr[HW-1:0]));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $past(!rd_n));
endmodule

bind bus_cycle_ctrl bcc_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_ack   (req_ack),
    .early_ack (early_ack),
    .data_ack  (data_ack),
    .rd_data   (rd_data),
    .bus_addr  (bus_addr),
    .bus_oe    (bus_oe),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_m      (io_m)
);

// File: tb/bus_cycle_ctrl_test.sv
module bus_cycle_ctrl_test;
    localparam int DLYL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack, early_ack, data_ack;
    logic [7:0]  rd_data;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic [7:0]  bus_din = '0;
    logic        rd_n, wr_n, io_m;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] exp_rd = 8'h00;

    always #2.5 clk = ~clk;

    bus_cycle_ctrl #(.AW(16), .DW(8), .DLY_LONG(DLYL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .early_ack(early_ack), .data_ack(data_ack), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_din(bus_din), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cycle_len(input logic [2:0] k);
        if (k >= 3'd1 && k <= 3'd4) return 3;
        if (k == 3'd5) return 1;
        if (k == 3'd6) return DLYL;
        return 0;
    endfunction

    function automatic logic [15:0] exp_addr(input logic [2:0] k, input logic [15:0] a);
        return (k == 3'd3 || k == 3'd4) ? {a[7:0], a[7:0]} : a;
    endfunction

    task automatic do_req(input logic [2:0] k, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] din);
        int  n    = cycle_len(k);
        bit  xfer = (k >= 3'd1 && k <= 3'd4);
        bit  io   = (k == 3'd3 || k == 3'd4);
        bit  rd   = (k == 3'd1 || k == 3'd3);
        bit  wr   = (k == 3'd2 || k == 3'd4);
        logic [15:0] ea = exp_addr(k, a);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
        #1;
        chk(n == 0 ? "R3 null ack" : "R2 accept", {31'd0, req_ack}, {31'd0, n != 0});
        chk("R8 accept early", {31'd0, early_ack}, {31'd0, k == 3'd5});
        if (n == 0) begin
            for (int c = 0; c < 2; c++) begin
                @(negedge clk); #1;
                chk("R3 idle", {28'd0, req_ack, rd_n, wr_n, data_ack}, {28'd0, 4'b0110});
            end
            chk("R10 null hold", {24'd0, rd_data}, {24'd0, exp_rd});
            req_valid = 1'b0;
            return;
        end
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            req_valid = 1'($urandom); req_kind = 3'($urandom); req_addr = 16'($urandom);
            if (c == 2) bus_din = din;
            #1;
            chk("R2 busy no ack", {31'd0, req_ack}, 32'd0);
            chk("R6 early", {31'd0, early_ack}, {31'd0, c == n - 1});
            chk("R6 data", {31'd0, data_ack}, {31'd0, c == n});
            if (xfer) begin
                chk("R7 addr", {16'd0, bus_addr}, {16'd0, ea});
                chk("R7 io_m", {31'd0, io_m}, {31'd0, io});
                chk("R4 rd_n", {31'd0, rd_n}, {31'd0, !(rd && c == 2)});
                chk("R5 wr_n", {31'd0, wr_n}, {31'd0, !(wr && c == 2)});
                chk("R5 bus_oe", {31'd0, bus_oe}, {31'd0, wr});
                if (wr) chk("R5 bus_dout", {24'd0, bus_dout}, {24'd0, wd});
            end else begin
                chk(k == 3'd5 ? "R8 quiet" : "R9 quiet",
                    {29'd0, rd_n, wr_n, bus_oe}, {29'd0, 3'b110});
            end
            if (c == n) begin
                if (rd) begin
                    exp_rd = din;
                    chk("R4 rd_data", {24'd0, rd_data}, {24'd0, exp_rd});
                end else begin
                    chk("R10 hold", {24'd0, rd_data}, {24'd0, exp_rd});
                end
            end
        end
        req_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 reset", {26'd0, rd_n, wr_n, req_ack, early_ack, data_ack, bus_oe}, {26'd0, 6'b110000});
        chk("R1 reset io", {31'd0, io_m}, 32'd0);
        chk("R1 reset rd_data", {24'd0, rd_data}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 after reset", {27'd0, rd_n, wr_n, req_ack, early_ack, data_ack}, {27'd0, 5'b11000});

        // Directed corners
        do_req(3'd1, 16'hFFFF, 8'h00, 8'hA5);   // R4
        do_req(3'd4, 16'hAB12, 8'h3C, 8'h00);   // R7 R5
        do_req(3'd3, 16'h0080, 8'h00, 8'h5A);   // R7 R4
        do_req(3'd2, 16'h1234, 8'hC3, 8'hFF);   // R5 R10
        do_req(3'd5, 16'h0000, 8'h00, 8'h11);   // R8
        do_req(3'd6, 16'h0000, 8'h00, 8'h22);   // R9
        do_req(3'd0, 16'h4444, 8'h00, 8'h33);   // R3
        do_req(3'd7, 16'h5555, 8'h00, 8'h44);   // R3

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            do_req(3'($urandom), 16'($urandom), 8'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule